// File: doc/BRIEF.md
# Small 32-bit Integer Execution Core

This block is a single-issue 32-bit integer core built to run short load, add and store programs. In each cycle it reads one 32-bit instruction from a program memory port. That port is addressed by word and returns its data within the same cycle. The core decodes the instruction, reads two operands from a bank of thirty-two 32-bit registers and adds them. It then writes the result back or moves data through a synchronous data memory port.

The core supports five operations:
- register-register add;
- add of a sign-extended 16-bit constant;
- word load;
- byte load with zero extension;
- word store.

Loads and stores form their address as a base register plus a sign-extended 16-bit displacement. Register 0 always reads as zero. With register 0 as the base, a displacement alone names an absolute location.

The data memory returns read data one cycle after the request. For that reason every load holds the instruction for one extra cycle, and the result is written back in that second cycle. Any other encoding does nothing except move on to the next instruction.

Top module: `tic_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, the core fetches word index 0 and drives both the read strobe and the write strobe low.
- R2: Register 0 reads as zero in every cycle. Any write aimed at register 0 is discarded.
- R3: Opcode bits [5:0] = 0x3A select the register-register format: source A in [31:27], source B in [26:22], destination in [21:17] and the secondary operation in [16:11]. Secondary operation 0x31 writes A + B to the destination, so word 0x1905883A gives r2 = r3 + r4.
- R4: Opcode 0x04 writes A + sext(imm16) to register B, where the immediate is bits [21:6], A is bits [31:27] and B is bits [26:22]. Word 0x94400704 gives r17 = r18 + 28. A negative immediate such as 0xFFFD adds -3.
- R5: Opcode 0x17 (word load) places A + sext(imm16) on the data address and pulses the read strobe for exactly one cycle. The fetch index then stays unchanged for one extra cycle, and register B receives the full word that was read.
- R6: Opcode 0x03 (byte load) writes into register B the byte at lane address[1:0] of the word that was read, with lane 0 in bits [7:0]. The upper 24 bits are filled with zeros.
- R7: Opcode 0x15 (word store) holds the write strobe for one cycle and drives address A + sext(imm16) and data equal to register B. The read strobe and the write strobe are never high together.
- R8: After any instruction that is not a load, and after the second cycle of a load, the word fetch index grows by one, so the byte program counter grows by 4.
- R9: Any other primary opcode, and any register-register word whose secondary operation is not 0x31, changes no register and no memory. The fetch index still moves on by one.
- R10: With base register 0, a load or store reaches the absolute address given by the displacement. A base register plus a negative displacement reaches a lower address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | IMEM_AW | Word index of the instruction to fetch |
| imem_rdata | input | 32 | Instruction word, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_re | output | 1 | Read strobe; data returns on the next cycle |
| dmem_rdata | input | 32 | Read data for the previous cycle's strobe |
| dmem_we | output | 1 | Write strobe for a full word |
| dmem_wdata | output | 32 | Word to store |

## Verification
The assertions assume a program memory that answers in the same cycle and a data memory that answers a read strobe on the next rising edge, with nothing between them. They also take the instruction word as stable while the fetch index is stable, which holds for any memory that only reads. The bench models both memories as plain arrays that meet these timings. It places every data access at a word-aligned or byte-sized address inside its small data array, and it fills unused program words with zero, which decodes as a no-op.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [5:0] OPC_RFORM = 6'h3A;
  localparam logic [5:0] OPC_ADDI  = 6'h04;
  localparam logic [5:0] OPC_LDW   = 6'h17;
  localparam logic [5:0] OPC_STW   = 6'h15;
  localparam logic [5:0] OPC_LDBU  = 6'h03;
  localparam logic [5:0] SUB_ADD   = 6'h31;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_ADDI, K_LDW, K_LDBU, K_STW
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] rc;
    logic [XLEN-1:0]   imm;
  } dec_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] add32(input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] lane_byte(input logic [XLEN-1:0] w,
                                                input logic [1:0] lane);
    return {{(XLEN-8){1'b0}}, w[8*lane +: 8]};
  endfunction
endpackage

// File: rtl/tic_decode.sv
module tic_decode
  import tic_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [5:0] opc;
  logic [5:0] sub;

  assign opc = instr[5:0];
  assign sub = instr[16:11];

  always_comb begin
    dec.ra  = instr[31:27];
    dec.rb  = instr[26:22];
    dec.rc  = instr[21:17];
    dec.imm = sext16(instr[21:6]);
    unique case (opc)
      OPC_RFORM: dec.kind = (sub == SUB_ADD) ? K_ADD : K_NOP;
      OPC_ADDI:  dec.kind = K_ADDI;
      OPC_LDW:   dec.kind = K_LDW;
      OPC_LDBU:  dec.kind = K_LDBU;
      OPC_STW:   dec.kind = K_STW;
      default:   dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/tic_regfile.sv
module tic_regfile
  import tic_pkg::*;
#(
  parameter int N  = NREG,
  parameter int W  = XLEN,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  rb_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] bank [N];
  logic         wr_take;

  assign wr_take = wr_en && (wr_idx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) bank[i] <= '0;
    end else if (wr_take) begin
      bank[wr_idx] <= wr_data;
    end
  end

  assign ra_data = (ra_idx == '0) ? '0 : bank[ra_idx];
  assign rb_data = (rb_idx == '0) ? '0 : bank[rb_idx];

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == '0) |-> (ra_data == '0)); // R2
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_idx == '0) |-> (rb_data == '0)); // R2
endmodule

// File: rtl/tic_core.sv
module tic_core
  import tic_pkg::*;
#(
  parameter int IMEM_AW = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [31:0]        imem_rdata,
  output logic [31:0]        dmem_addr,
  output logic               dmem_re,
  input  logic [31:0]        dmem_rdata,
  output logic               dmem_we,
  output logic [31:0]        dmem_wdata
);
  logic [IMEM_AW-1:0] pc_w;
  logic               wait_q;
  dec_t               dec;
  logic [XLEN-1:0]    opa, opb, eff_addr, alu_res, ld_res;
  logic               is_load, load_issue, pc_step;
  logic               wb_en;
  logic [RIDX_W-1:0]  wb_idx;
  logic [XLEN-1:0]    wb_data;

  tic_decode u_dec (.instr(imem_rdata), .dec(dec));

  tic_regfile #(.N(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(dec.ra), .ra_data(opa),
    .rb_idx(dec.rb), .rb_data(opb),
    .wr_en(wb_en), .wr_idx(wb_idx), .wr_data(wb_data)
  );

  assign is_load    = (dec.kind == K_LDW) || (dec.kind == K_LDBU);
  assign load_issue = is_load && !wait_q;
  assign pc_step    = !load_issue;

  assign eff_addr = add32(opa, dec.imm);
  assign alu_res  = (dec.kind == K_ADD) ? add32(opa, opb) : eff_addr;
  assign ld_res   = (dec.kind == K_LDW) ? dmem_rdata
                                        : lane_byte(dmem_rdata, eff_addr[1:0]);

  always_comb begin
    wb_en   = 1'b0;
    wb_idx  = dec.rb;
    wb_data = alu_res;
    unique case (dec.kind)
      K_ADD:  begin wb_en = 1'b1; wb_idx = dec.rc; end
      K_ADDI: begin wb_en = 1'b1; end
      K_LDW, K_LDBU: begin wb_en = wait_q; wb_data = ld_res; end
      default: wb_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_w   <= '0;
      wait_q <= 1'b0;
    end else begin
      wait_q <= load_issue;
      if (pc_step) pc_w <= pc_w + 1'b1;
    end
  end

  assign imem_addr  = pc_w;
  assign dmem_addr  = eff_addr;
  assign dmem_re    = rst_n && load_issue;
  assign dmem_we    = rst_n && (dec.kind == K_STW);
  assign dmem_wdata = opb;

  AST_LOAD_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> (imem_addr == $past(imem_addr))); // R5
  AST_LOAD_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> !dmem_re); // R5
  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !dmem_re |=> (imem_addr == IMEM_AW'($past(imem_addr) + 1'b1))); // R8
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_re && dmem_we)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (imem_addr == '0)); // R1
endmodule

// File: tb/tic_core_bench.sv
module tic_core_bench;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic [31:0]   dmem_addr;
  logic          dmem_re;
  logic [31:0]   dmem_rdata;
  logic          dmem_we;
  logic [31:0]   dmem_wdata;

  logic [31:0] prog [64];
  logic [31:0] ram  [64];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tic_core #(.IMEM_AW(AW)) u_tic_core (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata)
  );

  assign imem_rdata = prog[imem_addr[5:0]];

  always @(posedge clk) begin
    if (dmem_re) dmem_rdata <= ram[dmem_addr[7:2]];
    if (dmem_we) ram[dmem_addr[7:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] enc_r(input int a, input int b, input int c,
                                        input logic [5:0] sub);
    return {a[4:0], b[4:0], c[4:0], sub, 5'd0, 6'h3A};
  endfunction
  function automatic logic [31:0] enc_i(input int a, input int b,
                                        input logic [15:0] imm, input logic [5:0] op);
    return {a[4:0], b[4:0], imm, op};
  endfunction
  function automatic logic [31:0] addi(input int b, input int a, input logic [15:0] k);
    return enc_i(a, b, k, 6'h04);
  endfunction
  function automatic logic [31:0] stw(input int b, input logic [15:0] k);
    return enc_i(0, b, k, 6'h15);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 64; i++) begin prog[i] = 32'h0; ram[i] = 32'h0; end
  endtask

  task automatic run(input int n);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    wipe();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 fetch in reset", 32'(imem_addr), 0);
    chk("R1 strobes in reset", {30'd0, dmem_re, dmem_we}, 0);
    rst_n = 1'b1;
    chk("R1 fetch after reset", 32'(imem_addr), 0);
  endtask

  task automatic t_known_words();
    wipe();
    prog[0] = addi(3, 0, 16'd5);
    prog[1] = addi(4, 0, 16'd7);
    prog[2] = 32'h1905883A;
    prog[3] = addi(18, 0, 16'd100);
    prog[4] = 32'h94400704;
    prog[5] = stw(2, 16'h40);
    prog[6] = stw(17, 16'h44);
    run(20);
    chk("R3 add r2=r3+r4", ram[16], 32'd12);
    chk("R4 addi r17=r18+28", ram[17], 32'd128);
  endtask

  task automatic t_sign_ext();
    wipe();
    prog[0] = addi(5, 0, 16'hFFFD);
    prog[1] = addi(6, 5, 16'd10);
    prog[2] = stw(5, 16'h40);
    prog[3] = stw(6, 16'h44);
    run(15);
    chk("R4 negative immediate", ram[16], 32'hFFFF_FFFD);
    chk("R4 add after negative", ram[17], 32'd7);
  endtask

  task automatic t_loads();
    wipe();
    ram[32] = 32'hA1B2C3D4;
    ram[33] = 32'h11223344;
    prog[0] = enc_i(0, 7, 16'h80, 6'h17);
    prog[1] = enc_i(0, 8, 16'h81, 6'h03);
    prog[2] = enc_i(0, 9, 16'h83, 6'h03);
    prog[3] = addi(10, 0, 16'h80);
    prog[4] = enc_i(10, 11, 16'd4, 6'h17);
    prog[5] = addi(12, 0, 16'h90);
    prog[6] = enc_i(12, 13, 16'hFFF4, 6'h17);
    prog[7] = enc_i(0, 14, 16'h80, 6'h03);
    prog[8] = stw(7, 16'hC0);
    prog[9] = stw(8, 16'hC4);
    prog[10] = stw(9, 16'hC8);
    prog[11] = stw(11, 16'hCC);
    prog[12] = stw(13, 16'hD0);
    prog[13] = stw(14, 16'hD4);
    run(40);
    chk("R5 R10 word load absolute", ram[48], 32'hA1B2C3D4);
    chk("R6 byte lane 1", ram[49], 32'h0000_00C3);
    chk("R6 byte lane 3", ram[50], 32'h0000_00A1);
    chk("R5 base plus displacement", ram[51], 32'h11223344);
    chk("R10 negative displacement", ram[52], 32'h11223344);
    chk("R6 byte lane 0", ram[53], 32'h0000_00D4);
  endtask

  task automatic t_zero_reg();
    wipe();
    prog[0] = addi(0, 0, 16'd55);
    prog[1] = enc_r(0, 0, 0, 6'h31);
    prog[2] = stw(0, 16'h40);
    prog[3] = addi(1, 0, 16'd9);
    prog[4] = stw(1, 16'h44);
    run(15);
    chk("R2 register 0 stays zero", ram[16], 32'd0);
    chk("R2 r0 base reads zero", ram[17], 32'd9);
  endtask

  task automatic t_noops();
    wipe();
    prog[0] = addi(2, 0, 16'd1);
    prog[1] = addi(3, 0, 16'd4);
    prog[2] = enc_r(3, 3, 2, 6'h05);
    prog[3] = {addi(2, 3, 16'd20)} & 32'hFFFF_FFC0 | 32'h3F;
    prog[4] = stw(2, 16'h40);
    run(15);
    chk("R9 unknown ops leave register", ram[16], 32'd1);
    chk("R9 no stray store", ram[0], 32'd0);
  endtask

  task automatic t_timing();
    wipe();
    ram[32] = 32'hCAFEF00D;
    prog[0] = addi(4, 0, 16'd3);
    prog[1] = enc_i(0, 5, 16'h80, 6'h17);
    prog[2] = stw(5, 16'h44);
    prog[3] = 32'hFFFF_FFFF;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R8 first fetch", 32'(imem_addr), 0);
    @(negedge clk);
    chk("R8 fetch after alu", 32'(imem_addr), 1);
    chk("R5 read strobe", {31'd0, dmem_re}, 1);
    chk("R5 R10 load address", dmem_addr, 32'h80);
    @(negedge clk);
    chk("R5 stall holds fetch", 32'(imem_addr), 1);
    chk("R5 single strobe", {31'd0, dmem_re}, 0);
    @(negedge clk);
    chk("R8 fetch after load", 32'(imem_addr), 2);
    chk("R7 write strobe", {31'd0, dmem_we}, 1);
    chk("R7 store address", dmem_addr, 32'h44);
    chk("R7 store data", dmem_wdata, 32'hCAFEF00D);
    chk("R7 strobes exclusive", {31'd0, dmem_re}, 0);
    @(negedge clk);
    chk("R9 nop still advances", 32'(imem_addr), 3);
    chk("R7 strobe one cycle", {31'd0, dmem_we}, 0);
    @(negedge clk);
    chk("R9 all-ones word advances", 32'(imem_addr), 4);
    chk("R7 store landed", ram[17], 32'hCAFEF00D);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_known_words();
    t_sign_ext();
    t_loads();
    t_zero_reg();
    t_noops();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule